// File: doc/BRIEF.md
# Banked Indirect Test-Register Window

This block is the register-file end of a PHY management port. Three registers of the ordinary 32-entry register map serve as a window: a control word, a write-data register and a read-data register. Behind the window sit four banks of 32 sixteen-bit registers. Bank 0 holds analog and DSP settings. Bank 1 holds wake-on-LAN settings. Bank 3 holds self-test settings, which include a fractional-PLL control at index 0x1b and its dividers at 0x1c and 0x1d. Bank 2 is a hole. The bank contents are plain storage. The serial management framing lives elsewhere, and this block sees only single-cycle register writes and a combinational register read.

The hidden banks are locked after reset. Software opens them by writing a fixed four-step pattern to the control word. The steps toggle only the test-mode bit. Once the banks are open, each control write carrying test-mode and a strobe performs one banked access. A write commits the value held in the write-data register. A read loads the read-data register, where software then fetches the result. Writing zero to the control word locks the banks again.

Top module: `tstreg_window`

## Requirements
- R1: After reset, base registers 20 (control), 21 (read data) and 23 (write data) all read 0x0000, and the banks are locked.
- R2: Register 23 reads back the last value written to it. Register 21 ignores host writes. Any base address other than 20, 21 and 23 reads 0x0000.
- R3: The banks open only after the control word receives exactly these values in order: 0x0000, 0x0400, 0x0000, 0x0400. Bit 10 is test-mode.
- R4: A control write that does not match the expected step restarts the pattern. If that write is 0x0000, it counts as the first step of the new pattern.
- R5: While open, a control write with bit 14 (write strobe) and bit 10 set commits register 23 into the bank given by bits 12:11, at the index given by bits 4:0.
- R6: While open, a control write with bit 15 (read strobe) and bit 10 set reads the bank given by bits 12:11 at the index given by bits 9:5. Register 21 shows the result from the second clock edge after that write.
- R7: Register 20 reads back the written word for one cycle. From the following cycle on, bits 15:14 read as zero and the other bits are kept.
- R8: While locked, strobes change no bank contents, and register 21 keeps its value.
- R9: Writing 0x0000 to the control word locks the banks. While open, any control write with bit 10 clear also locks them.
- R10: Bank 2 reads as zero, and writes to it are dropped without touching the other banks.
- R11: The same index in different banks holds independent values.
- R12: A single command with both strobes set returns the pre-write contents in register 21 and commits the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_we | input | 1 | Base register write strobe, one cycle per write |
| mgmt_addr | input | 5 | Base register address |
| mgmt_wdata | input | 16 | Base register write value |
| mgmt_rdata | output | 16 | Base register read value for mgmt_addr (combinational) |

## Verification
The bench sweeps every index of the three live banks with distinct computed values. A design that decodes the bank or index fields wrongly then returns another slot's value, and one that aliases bank 2 onto a live bank corrupts that bank. It breaks the unlock pattern mid-way, including a stray zero. A tracker that fails to restart, or that does not count the zero as a fresh first step, then opens too early or never. It issues strobes while locked and after both kinds of close, and then checks that storage and the read-data register were left untouched. It also checks exactly when the strobe bits clear, and that a combined read-and-write command returns the old contents.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int REGW  = 16;
    localparam int IDXW  = 5;
    localparam int BANKW = 2;

    localparam logic [4:0] A_CTL  = 5'd20;
    localparam logic [4:0] A_RDAT = 5'd21;
    localparam logic [4:0] A_WDAT = 5'd23;

    localparam int B_RD   = 15;
    localparam int B_WR   = 14;
    localparam int B_BANK = 11;
    localparam int B_TM   = 10;
    localparam int B_RIDX = 5;
    localparam int B_WIDX = 0;

    localparam logic [REGW-1:0] TM_ONLY = 16'h0400;

    typedef enum logic [2:0] {
        UL_IDLE,
        UL_Z1,
        UL_T1,
        UL_Z2,
        UL_OPEN
    } ul_state_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [BANKW-1:0] bank;
        logic [IDXW-1:0]  ridx;
        logic [IDXW-1:0]  widx;
    } cmd_t;
endpackage

// File: rtl/tw_unlock.sv
module tw_unlock
    import tw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [REGW-1:0] ctl_val,
    output logic            open_o
);
    ul_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            if (ctl_val == '0) begin
                st_d = (st_q == UL_T1) ? UL_Z2 : UL_Z1;
            end else if (ctl_val == TM_ONLY) begin
                case (st_q)
                    UL_Z1:   st_d = UL_T1;
                    UL_Z2:   st_d = UL_OPEN;
                    UL_OPEN: st_d = UL_OPEN;
                    default: st_d = UL_IDLE;
                endcase
            end else begin
                st_d = (st_q == UL_OPEN && ctl_val[B_TM]) ? UL_OPEN : UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign open_o = (st_q == UL_OPEN);

    // R3: opening is always caused by a test-mode-only write
    p_open_on_tm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(ctl_we && ctl_val == TM_ONLY));

    // R9: a zero control write always locks
    p_zero_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_val == '0) |=> !open_o);
endmodule

// File: rtl/tw_banks.sv
module tw_banks #(
    parameter int               NBANK = 4,
    parameter int               DEPTH = 32,
    parameter int               W     = 16,
    parameter logic [NBANK-1:0] LIVE  = 4'b1011
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NBANK)-1:0] wr_bank,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(NBANK)-1:0] rd_bank,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int BW = $clog2(NBANK);

    logic [W-1:0] bank_out [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if (LIVE[b]) begin : g_live
            logic [W-1:0] mem_d [DEPTH];
            logic [W-1:0] mem_q [DEPTH];

            always_comb begin
                mem_d = mem_q;
                if (wr_en && wr_bank == BW'(b)) mem_d[wr_idx] = wr_data;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
                end else begin
                    mem_q <= mem_d;
                end
            end

            assign bank_out[b] = mem_q[rd_idx];
        end else begin : g_hole
            assign bank_out[b] = '0;
        end
    end

    assign rd_data = bank_out[rd_bank];
endmodule

// File: rtl/tstreg_window.sv
module tstreg_window
    import tw_pkg::*;
#(
    parameter int               NBANK = 4,
    parameter int               DEPTH = 32,
    parameter logic [NBANK-1:0] LIVE  = 4'b1011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_we,
    input  logic [4:0]  mgmt_addr,
    input  logic [15:0] mgmt_wdata,
    output logic [15:0] mgmt_rdata
);
    typedef struct packed {
        logic [REGW-1:0] ctrl;
        logic [REGW-1:0] wdat;
        logic [REGW-1:0] rdat;
        cmd_t            pend;
    } st_t;

    st_t s_d, s_q;
    logic ctl_we;
    logic open;
    logic [REGW-1:0] bank_rd;

    assign ctl_we = mgmt_we && (mgmt_addr == A_CTL);

    tw_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (ctl_we),
        .ctl_val (mgmt_wdata),
        .open_o  (open)
    );

    tw_banks #(.NBANK(NBANK), .DEPTH(DEPTH), .W(REGW), .LIVE(LIVE)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s_q.pend.wr),
        .wr_bank (s_q.pend.bank),
        .wr_idx  (s_q.pend.widx),
        .wr_data (s_q.wdat),
        .rd_bank (s_q.pend.bank),
        .rd_idx  (s_q.pend.ridx),
        .rd_data (bank_rd)
    );

    always_comb begin
        s_d = s_q;
        s_d.ctrl[B_RD] = 1'b0;
        s_d.ctrl[B_WR] = 1'b0;
        if (s_q.pend.rd) s_d.rdat = bank_rd;
        s_d.pend = '0;
        if (mgmt_we && mgmt_addr == A_WDAT) s_d.wdat = mgmt_wdata;
        if (ctl_we) begin
            s_d.ctrl = mgmt_wdata;
            if (open && mgmt_wdata[B_TM]) begin
                s_d.pend.rd   = mgmt_wdata[B_RD];
                s_d.pend.wr   = mgmt_wdata[B_WR];
                s_d.pend.bank = mgmt_wdata[B_BANK +: BANKW];
                s_d.pend.ridx = mgmt_wdata[B_RIDX +: IDXW];
                s_d.pend.widx = mgmt_wdata[B_WIDX +: IDXW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (mgmt_addr)
            A_CTL:   mgmt_rdata = s_q.ctrl;
            A_RDAT:  mgmt_rdata = s_q.rdat;
            A_WDAT:  mgmt_rdata = s_q.wdat;
            default: mgmt_rdata = '0;
        endcase
    end

    // R7: strobes are visible for only one cycle after a control write
    p_strobe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we ##1 !ctl_we) |=> (s_q.ctrl[B_RD:B_WR] == 2'b00));

    // R8: with the banks locked and no read in flight, read data holds
    p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !s_q.pend.rd) |=> $stable(s_q.rdat));
endmodule

// File: tb/sim_tstreg_window.sv
module sim_tstreg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tstreg_window u0 (
        .clk(clk), .rst_n(rst_n), .mgmt_we(we),
        .mgmt_addr(addr), .mgmt_wdata(wdata), .mgmt_rdata(rdata)
    );

    function automatic logic [15:0] pat(int b, int i);
        return (16'h1111 * 16'(b + 1)) ^ (16'(i) * 16'h0203) ^ 16'h00A5;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic peek(logic [4:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic unlock();
        put(20, 16'h0000); put(20, 16'h0400); put(20, 16'h0000); put(20, 16'h0400);
    endtask

    task automatic bwrite(int b, int i, logic [15:0] v);
        put(23, v);
        put(20, 16'h4400 | (16'(b) << 11) | 16'(i));
    endtask

    task automatic bread(int b, int i, output logic [15:0] v);
        put(20, 16'h8400 | (16'(b) << 11) | (16'(i) << 5));
        @(posedge clk);
        @(negedge clk);
        peek(21, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(20, v); chk("R1 ctrl", v, 16'h0000);
        peek(21, v); chk("R1 rdat", v, 16'h0000);
        peek(23, v); chk("R1 wdat", v, 16'h0000);

        // R2 base map
        put(23, 16'h1234); peek(23, v); chk("R2 wdat readback", v, 16'h1234);
        put(21, 16'hFFFF); peek(21, v); chk("R2 rdat read-only", v, 16'h0000);
        put(5, 16'hABCD);  peek(5, v);  chk("R2 other addr", v, 16'h0000);

        // R8 strobes while locked
        put(23, 16'hBEEF);
        put(20, 16'h4400 | 16'd3);
        put(20, 16'h8400 | (16'd3 << 5));
        @(posedge clk); @(negedge clk);
        peek(21, v); chk("R8 rdat held while locked", v, 16'h0000);

        // R4 broken pattern: 0, TM, break, 0, TM leaves it locked
        put(20, 16'h0000); put(20, 16'h0400); put(20, 16'h0405);
        put(20, 16'h0000); put(20, 16'h0400);
        bwrite(0, 7, 16'h7777);
        unlock();
        bread(0, 7, v); chk("R4 early command dropped", v, 16'h0000);
        bread(0, 3, v); chk("R8 locked write dropped", v, 16'h0000);

        // R4 stray zero counts as first step
        put(20, 16'h0000);
        put(20, 16'h0000); put(20, 16'h0400); put(20, 16'h0000); put(20, 16'h0000);
        put(20, 16'h0400); put(20, 16'h0000); put(20, 16'h0400);
        bwrite(1, 1, 16'h1A1A);
        bread(1, 1, v); chk("R4 zero restarts pattern", v, 16'h1A1A);

        // R3 R5 R6 R11 sweep of live banks
        for (int b = 0; b < 4; b++) begin
            if (b == 2) continue;
            for (int i = 0; i < 32; i++) bwrite(b, i, pat(b, i));
        end
        for (int b = 0; b < 4; b++) begin
            if (b == 2) continue;
            for (int i = 0; i < 32; i++) begin
                bread(b, i, v);
                chk("R5 R6 R11 sweep", v, pat(b, i));
            end
        end

        // R7 strobe self-clear
        put(20, 16'h8400 | (16'd1 << 11) | (16'd2 << 5));
        peek(20, v); chk("R7 strobe visible", v, 16'h8C40);
        @(posedge clk); @(negedge clk);
        peek(20, v); chk("R7 strobe cleared", v, 16'h0C40);
        peek(21, v); chk("R6 read timing", v, pat(1, 2));

        // R10 bank 2 hole
        bwrite(2, 5, 16'h2222);
        bread(2, 5, v); chk("R10 bank2 reads zero", v, 16'h0000);
        bread(0, 5, v); chk("R10 bank0 untouched", v, pat(0, 5));
        bread(3, 5, v); chk("R10 bank3 untouched", v, pat(3, 5));

        // R12 combined read and write
        put(23, 16'hC0DE);
        put(20, 16'hC400 | (16'd3 << 11) | (16'd4 << 5) | 16'd4);
        @(posedge clk); @(negedge clk);
        peek(21, v); chk("R12 old value returned", v, pat(3, 4));
        bread(3, 4, v); chk("R12 new value committed", v, 16'hC0DE);

        // R9 close by zero
        put(20, 16'h0000);
        peek(20, v); chk("R9 ctrl zero", v, 16'h0000);
        bwrite(0, 0, 16'hDEAD);
        unlock();
        bread(0, 0, v); chk("R9 zero closes", v, pat(0, 0));

        // R9 close by test-mode clear
        put(20, 16'h0001);
        bwrite(0, 1, 16'hDEAD);
        unlock();
        bread(0, 1, v); chk("R9 tm clear closes", v, pat(0, 1));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule